// File: doc/BRIEF.md
# Peripheral Reset Line Controller

This block sits on a simple 32-bit register bus and drives a bank of active-high reset outputs, one for each on-chip peripheral, plus a single-cycle request that resets the whole chip. Software asserts a peripheral's reset and later releases it by register writes. Each output holds the last level written until software changes it. The block adds no minimum hold time between assertion and release. Synchronising the reset into each target clock domain happens outside this block.

A build-time parameter selects one of two register layouts. In the level layout, each 32-bit word is an ordinary read/write register, and software changes one line with a read-modify-write. In the pair layout, each word of lines is reached through two addresses. Ones written to the first address raise lines, and ones written to the second address lower them. Zero bits leave their lines alone. In both layouts, a write to byte offset 0 with bit 31 set also raises the chip-wide reset request.

Top module: `rstc_periph_reset`

## Requirements
- R1: During and after the synchronous reset input `rst`, every peripheral reset output, `sys_rst_req` and `bus_rdata` are 0.
- R2: Line n (0 to 63) is bit n mod 32 of line word n/32. Line word k drives `periph_rst[32k+31:32k]`.
- R3: Level layout: a write to byte offset 4k (k = 0 or 1) loads line word k with the written data. From the next cycle, `periph_rst` shows that data.
- R4: Level layout: a read of byte offset 4k returns the current levels of the 32 lines in line word k.
- R5: Pair layout: a write to byte offset 8k raises every line of word k whose data bit is 1.
- R6: Pair layout: a write to byte offset 8k+4 lowers every line of word k whose data bit is 1. In either pair address, a data bit of 0 leaves its line unchanged.
- R7: Pair layout: a read of byte offset 8k or 8k+4 returns the current levels of line word k.
- R8: A write to byte offset 0 with data bit 31 set raises `sys_rst_req` for exactly the one cycle after the write. The request is not stored. The same write still updates line 31 as the layout dictates.
- R9: Offsets that map to no line word (level layout: 8 and above; pair layout: 16 and above) read as 0, and writes to them change no output.
- R10: `bus_rdata` is registered. It presents the read result in the cycle after `bus_ren`, and that result reflects the levels before any write in the same cycle. It is 0 in a cycle that follows no read.
- R11: Without a write to a mapped offset, every peripheral reset output keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address; the low two bits are ignored |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| periph_rst | output | 64 | Peripheral reset levels, line n on bit n |
| sys_rst_req | output | 1 | One-cycle chip-wide reset request |

## Verification
A write to offset 0 with bit 31 set does two things in the same cycle: it raises the chip reset request and updates line 31. The bench sends exactly such writes in both layouts and also mixes them into random traffic. It judges them against a behavioural model that predicts both effects on the following cycle. Reads and writes issued together to the same word are the second collision. The model expects the read to return the levels from before the write.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [0:0] {
    STYLE_LEVEL = 1'b0,
    STYLE_PAIR  = 1'b1
  } reg_style_e;

  typedef enum logic [1:0] {
    ACC_LEVEL = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/rstc_decode.sv
module rstc_decode
  import rstc_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         NUM_WORDS = 2,
  parameter reg_style_e STYLE     = STYLE_LEVEL
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wen,
  input  logic                 ren,
  input  logic                 wdata_msb,
  output logic [NUM_WORDS-1:0] wr_en,
  output acc_kind_e            wr_kind,
  output logic                 rd_hit,
  output logic [NUM_WORDS-1:0] rd_sel,
  output logic                 sys_hit
);

  localparam int WORD_AW = ADDR_W - 2;
  localparam int SHIFT   = (STYLE == STYLE_PAIR) ? 3 : 2;
  localparam int SLOT_W  = ADDR_W - SHIFT;

  logic [SLOT_W-1:0]  slot;
  logic               slot_ok;
  logic [WORD_AW-1:0] word_addr;

  assign word_addr = addr[ADDR_W-1:2];
  assign slot      = addr[ADDR_W-1:SHIFT];
  assign slot_ok   = (slot < SLOT_W'(NUM_WORDS));

  generate
    if (STYLE == STYLE_PAIR) begin : g_pair
      assign wr_kind = addr[2] ? ACC_CLR : ACC_SET;
    end else begin : g_level
      assign wr_kind = ACC_LEVEL;
    end
  endgenerate

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_sel
    logic match;
    assign match    = slot_ok && (slot == SLOT_W'(k));
    assign wr_en[k] = wen && match;
    assign rd_sel[k] = ren && match;
  end

  assign rd_hit  = ren && slot_ok;
  assign sys_hit = wen && (word_addr == '0) && wdata_msb;

endmodule

// File: rtl/rstc_word.sv
module rstc_word
  import rstc_pkg::*;
#(
  parameter reg_style_e STYLE = STYLE_LEVEL,
  parameter int         W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  acc_kind_e    wr_kind,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] level
);

  logic [W-1:0] level_q;
  logic [W-1:0] level_d;

  generate
    if (STYLE == STYLE_PAIR) begin : g_pair
      always_comb begin
        level_d = level_q;
        if (wr_en) begin
          case (wr_kind)
            ACC_SET: level_d = level_q | wdata;
            ACC_CLR: level_d = level_q & ~wdata;
            default: level_d = level_q;
          endcase
        end
      end
    end else begin : g_level
      always_comb begin
        level_d = level_q;
        if (wr_en && (wr_kind == ACC_LEVEL)) level_d = wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_d;
  end

  assign level = level_q;

  // R11: no write, no change
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(level));

  generate
    if (STYLE == STYLE_PAIR) begin : g_pair_chk
      // R5: set bits end up high
      p_set_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == ACC_SET) |=> ((level & $past(wdata)) == $past(wdata)));
      // R6: clear bits end up low
      p_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == ACC_CLR) |=> ((level & $past(wdata)) == '0));
      // R6: zero data bits leave lines untouched
      p_zero_keep_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((level ^ $past(level)) & ~$past(wdata)) == '0));
    end else begin : g_level_chk
      // R3: level write loads the word
      p_load_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (level == $past(wdata)));
    end
  endgenerate

endmodule

// File: rtl/rstc_readback.sv
module rstc_readback #(
  parameter int NUM_WORDS = 2,
  parameter int W         = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ren,
  input  logic                        rd_hit,
  input  logic [NUM_WORDS-1:0]        rd_sel,
  input  logic [NUM_WORDS-1:0][W-1:0] levels,
  output logic [W-1:0]                rdata
);

  logic [W-1:0] mux_out;
  logic [W-1:0] rdata_q;

  always_comb begin
    mux_out = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (rd_sel[k]) mux_out = mux_out | levels[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata_q <= '0;
    else if (ren && rd_hit) rdata_q <= mux_out;
    else                    rdata_q <= '0;
  end

  assign rdata = rdata_q;

  // R9: unmapped read returns zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (ren && !rd_hit) |=> (rdata == '0));
  // R10: no read, zero data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !ren |=> (rdata == '0));
  // R4 / R7: at most one word answers a read
  p_one_word_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_sel));

endmodule

// File: rtl/rstc_periph_reset.sv
module rstc_periph_reset
  import rstc_pkg::*;
#(
  parameter int         NUM_LINES = 64,
  parameter int         ADDR_W    = 8,
  parameter reg_style_e STYLE     = STYLE_LEVEL
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wen,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_ren,
  output logic [31:0]          bus_rdata,
  output logic [NUM_LINES-1:0] periph_rst,
  output logic                 sys_rst_req
);

  localparam int NUM_WORDS = NUM_LINES / WORD_W;

  logic [NUM_WORDS-1:0]             wr_en;
  logic [NUM_WORDS-1:0]             rd_sel;
  acc_kind_e                        wr_kind;
  logic                             rd_hit;
  logic                             sys_hit;
  logic                             sys_q;
  logic [NUM_WORDS-1:0][WORD_W-1:0] word_lvl;

  rstc_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .STYLE     (STYLE)
  ) u_decode (
    .addr      (bus_addr),
    .wen       (bus_wen),
    .ren       (bus_ren),
    .wdata_msb (bus_wdata[31]),
    .wr_en     (wr_en),
    .wr_kind   (wr_kind),
    .rd_hit    (rd_hit),
    .rd_sel    (rd_sel),
    .sys_hit   (sys_hit)
  );

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    rstc_word #(
      .STYLE (STYLE),
      .W     (WORD_W)
    ) u_word (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en[k]),
      .wr_kind (wr_kind),
      .wdata   (bus_wdata),
      .level   (word_lvl[k])
    );
  end

  rstc_readback #(
    .NUM_WORDS (NUM_WORDS),
    .W         (WORD_W)
  ) u_readback (
    .clk    (clk),
    .rst    (rst),
    .ren    (bus_ren),
    .rd_hit (rd_hit),
    .rd_sel (rd_sel),
    .levels (word_lvl),
    .rdata  (bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) sys_q <= 1'b0;
    else     sys_q <= sys_hit;
  end

  assign sys_rst_req = sys_q;
  assign periph_rst  = word_lvl;

  // R8: a request only follows a qualifying write
  p_sys_cause_r8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> ($past(bus_wen) && ($past(bus_addr[ADDR_W-1:2]) == '0) && $past(bus_wdata[31])));
  // R8: a qualifying write always raises the request next cycle
  p_sys_fire_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && (bus_addr[ADDR_W-1:2] == '0) && bus_wdata[31]) |=> sys_rst_req);
  // R9: unmapped write selects no word
  p_wr_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  // R11: idle bus keeps every line
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_wen |=> $stable(periph_rst));

endmodule

// File: tb/test_rstc_periph_reset.sv
module test_rstc_periph_reset;
  import rstc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;

  logic [31:0] rd_l, rd_p;
  logic [63:0] lines_l, lines_p;
  logic        sys_l, sys_p;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R1";
  bit    started  = 0;
  bit    done     = 0;

  // model state
  logic [63:0] m_lv_l = '0, m_lv_p = '0;
  logic [31:0] m_rd_l = '0, m_rd_p = '0;
  logic        m_sys  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rstc_periph_reset #(.STYLE(STYLE_LEVEL)) i_rstc_periph_reset (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(rd_l),
    .periph_rst(lines_l), .sys_rst_req(sys_l));

  rstc_periph_reset #(.STYLE(STYLE_PAIR)) i_rstc_periph_reset_pair (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(rd_p),
    .periph_rst(lines_p), .sys_rst_req(sys_p));

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int w;
    started = 1;
    if (rst) begin
      m_lv_l = '0; m_lv_p = '0; m_rd_l = '0; m_rd_p = '0; m_sys = 1'b0;
    end else begin
      w = int'(bus_addr) / 4;
      m_rd_l = (bus_ren && w < 2) ? m_lv_l[w*32 +: 32] : 32'h0;
      w = int'(bus_addr) / 8;
      m_rd_p = (bus_ren && w < 2) ? m_lv_p[w*32 +: 32] : 32'h0;
      m_sys  = bus_wen && (int'(bus_addr) / 4 == 0) && bus_wdata[31];
      if (bus_wen) begin
        w = int'(bus_addr) / 4;
        if (w < 2) m_lv_l[w*32 +: 32] = bus_wdata;
        w = int'(bus_addr) / 8;
        if (w < 2) begin
          if (bus_addr[2]) m_lv_p[w*32 +: 32] = m_lv_p[w*32 +: 32] & ~bus_wdata;
          else             m_lv_p[w*32 +: 32] = m_lv_p[w*32 +: 32] | bus_wdata;
        end
      end
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("level lines",  lines_l, m_lv_l);
      check("pair lines",   lines_p, m_lv_p);
      check("level rdata",  {32'h0, rd_l}, {32'h0, m_rd_l});
      check("pair rdata",   {32'h0, rd_p}, {32'h0, m_rd_p});
      check("level sysreq", {63'h0, sys_l}, {63'h0, m_sys});
      check("pair sysreq",  {63'h0, sys_p}, {63'h0, m_sys});
    end
  end

  task automatic op(input bit we, input bit re, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = we; bus_ren = re; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    op(0, 0, 8'h00, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    check("reset lines", lines_l | lines_p, 64'h0);
    check("reset rdata", {32'h0, rd_l | rd_p}, 64'h0);
    rst = 1'b0;
    idle();
    // R3 level loads; pair sees SET0 / CLR0
    phase = "R3";
    op(1, 0, 8'h00, 32'h0000_00F0);
    op(1, 0, 8'h04, 32'hA5A5_0001);
    idle();
    // R4 readback of both level words
    phase = "R4";
    op(0, 1, 8'h00, 32'h0);
    op(0, 1, 8'h04, 32'h0);
    idle();
    // R2 one line at a time
    phase = "R2";
    for (int n = 0; n < 64; n += 9) begin
      op(1, 0, 8'((n / 32) * 4), 32'(1) << (n % 32));
      op(1, 0, 8'((n / 32) * 8), 32'(1) << (n % 32));
    end
    // R5 set on word 1 (unmapped for level style)
    phase = "R5";
    op(1, 0, 8'h08, 32'hF00F_0FF0);
    op(1, 0, 8'h00, 32'h0000_000F);
    // R6 clears with mixed zero bits
    phase = "R6";
    op(1, 0, 8'h0C, 32'h3000_0030);
    op(1, 0, 8'h04, 32'h0000_0003);
    op(1, 0, 8'h0C, 32'h0);
    // R7 read set and clear aliases
    phase = "R7";
    op(0, 1, 8'h00, 32'h0);
    op(0, 1, 8'h04, 32'h0);
    op(0, 1, 8'h08, 32'h0);
    op(0, 1, 8'h0C, 32'h0);
    idle();
    // R8 chip reset request together with line 31
    phase = "R8";
    op(1, 0, 8'h00, 32'h8000_0000);
    idle();
    op(1, 0, 8'h04, 32'h8000_0000);
    op(1, 0, 8'h00, 32'h8000_0001);
    op(1, 0, 8'h00, 32'h8000_0000);
    idle(); idle();
    // R9 unmapped offsets
    phase = "R9";
    op(1, 0, 8'h40, 32'hFFFF_FFFF);
    op(1, 0, 8'hFC, 32'hFFFF_FFFF);
    op(0, 1, 8'h40, 32'h0);
    op(0, 1, 8'h10, 32'h0);
    idle();
    // R10 read and write to the same word together
    phase = "R10";
    op(1, 1, 8'h00, 32'h1234_5678);
    op(1, 1, 8'h04, 32'h0000_FFFF);
    op(1, 1, 8'h08, 32'h5555_0000);
    idle();
    // R11 quiet bus, lines hold
    phase = "R11";
    repeat (5) idle();
    op(0, 1, 8'h00, 32'h0);
    idle();
    // mixed random traffic
    phase = "R11 random";
    for (int i = 0; i < 400; i++) begin
      op(1'($urandom), 1'($urandom), 8'(($urandom % 20) * 4), $urandom);
    end
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule